// File: doc/BRIEF.md
# Strobed Host Bus Slave

This block connects a host processor bus to a terminal's internal storage. The host bus is asynchronous and uses active-low strobes. The internal side has two targets: a small bank of 16-bit registers and one port of a dual-port shared memory. The memory's other port belongs to the protocol engine, so a host access never has to wait for it.

Each access is framed by a strobe and a select. A space input chooses memory or registers, and a direction input chooses read or write. When both the strobe and the select are seen low at a rising clock edge, the slave pulls its buffer-enable output low. One clock later it pulls ready low. A write lands in the target at the edge where ready falls. A read places its data on the data bus while ready is low. As soon as the strobe or the select goes high, both outputs return high without waiting for a clock edge. An address pass control either lets the host address straight through or holds the address sampled at the last clock edge at which pass was high. The held mode supports hosts that share pins between address and data.

Top module: `hbus_slave`

## Requirements
- R1: `buf_en_n` falls at the first rising clock edge at which `strb_n` and `sel_n` are both sampled low.
- R2: `ready_n` falls exactly one clock edge after `buf_en_n` falls, for reads and writes in both spaces.
- R3: A rise of `strb_n` or `sel_n` drives `buf_en_n` and `ready_n` high at once, without waiting for a clock edge.
- R4: While the strobe stays low after ready has fallen, both outputs stay low and the access writes its target only once.
- R5: A memory write (`space_mem`=1, `host_rd`=0) asserts `mem_en` and `mem_we` for exactly the one cycle between the fall of `buf_en_n` and the fall of `ready_n`, with `mem_addr` equal to the effective address and `mem_wdata` equal to the host data.
- R6: During a memory read (`space_mem`=1, `host_rd`=1), `host_rdata` carries the word stored at the effective address while `ready_n` is low. A word that was never written reads as zero.
- R7: A register write (`space_mem`=0, `host_rd`=0) to index i < NUM_REGS updates bits [16i+15:16i] of `reg_values` at the edge where `ready_n` falls.
- R8: During a register read, `host_rdata` carries the addressed register while `ready_n` is low.
- R9: A register address of NUM_REGS or above reads as zero, and a write to it leaves every register unchanged.
- R10: `host_rdata_oe` is high only while `buf_en_n` is low and `host_rd` is 1, so the bus is never driven during a write.
- R11: When `addr_pass` is 1 the effective address is `host_addr`. When it is 0, the effective address is the value `host_addr` had at the last rising edge at which `addr_pass` was 1.
- R12: Under reset, both outputs are high, the data bus is not driven, no memory cycle occurs and every register is zero.
- R13: With `sel_n` high, a low strobe starts no access: outputs stay high and no memory cycle occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strb_n | input | 1 | Host strobe, active low, asynchronous |
| sel_n | input | 1 | Host select, active low, asynchronous |
| space_mem | input | 1 | 1 = shared memory, 0 = register bank |
| host_rd | input | 1 | 1 = read, 0 = write |
| addr_pass | input | 1 | 1 = address passes straight through, 0 = held address |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Write data from the host |
| host_rdata | output | DATA_W | Read data to the host |
| host_rdata_oe | output | 1 | Data bus drive enable |
| buf_en_n | output | 1 | Buffer enable, active low |
| ready_n | output | 1 | Transfer ready, active low |
| mem_en | output | 1 | Shared memory port enable |
| mem_we | output | 1 | Shared memory write enable |
| mem_addr | output | ADDR_W | Shared memory address |
| mem_wdata | output | DATA_W | Shared memory write data |
| mem_rdata | input | DATA_W | Shared memory read data, one cycle after `mem_en` |
| reg_values | output | NUM_REGS*DATA_W | Register bank contents for the protocol side |

## Verification
The assertions assume the following about the inputs:
- Reset is applied while the strobe is high.
- The space, direction, address and write data inputs stay steady while the strobe is low.
- `mem_rdata` comes from a synchronous memory with one cycle of read latency.

The bench changes every input half a period away from the sampling edge, so each edge sees settled values. Strobe and select rises happen between edges, which exercises the clock-free release. Control inputs change only while the strobe is high, except where a test deliberately holds the select high against a low strobe.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_READY  = 2'd2
    } hbus_state_e;

endpackage

// File: rtl/hbus_fsm.sv
module hbus_fsm
    import hbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strb_n,
    input  logic        sel_n,
    output hbus_state_e st_o,
    output logic        buf_en_n,
    output logic        ready_n
);

    typedef struct packed {
        hbus_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    logic      clr_n;
    logic      framed;

    // The access frame is open only while strobe and select are both low.
    assign framed = ~strb_n & ~sel_n;
    assign clr_n  = rst_n & framed;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE:   r_d.st = ST_ACCESS;
            ST_ACCESS: r_d.st = ST_READY;
            ST_READY:  r_d.st = ST_READY;
            default:   r_d.st = ST_IDLE;
        endcase
    end

    // State is forced idle, without a clock, whenever the frame closes.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) r_q <= '{st: ST_IDLE};
        else        r_q <= r_d;
    end

    assign st_o     = r_q.st;
    assign buf_en_n = ~((r_q.st != ST_IDLE) & framed);
    assign ready_n  = ~((r_q.st == ST_READY) & framed);

    AST_ACCESS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACCESS) |=> (r_q.st != ST_ACCESS)); // R2

    AST_READY_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_READY) |-> $past(r_q.st != ST_IDLE)); // R2

    AST_READY_IMPLIES_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_n |-> !buf_en_n); // R2

endmodule

// File: rtl/hbus_addr_latch.sv
module hbus_addr_latch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pass,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    typedef struct packed {
        logic [ADDR_W-1:0] hold;
    } latch_regs_t;

    latch_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (pass) r_d.hold = addr_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Pass high behaves as a transparent latch; pass low holds the last sample.
    assign addr_out = pass ? addr_in : r_q.hold;

    AST_HELD_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && $past(!pass)) |-> $stable(addr_out)); // R11

endmodule

// File: rtl/hbus_regbank.sv
module hbus_regbank #(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

    logic [NUM_REGS-1:0]             hit;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d, regs_q;

    // One decoder per register; an address beyond the bank hits nothing.
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_dec
        assign hit[gi] = (addr == ADDR_W'(gi));
        assign regs_flat[gi*DATA_W +: DATA_W] = regs_q[gi];
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && hit[i]) regs_d[i] = wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) rdata = regs_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    AST_OUT_OF_RANGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(addr) >= NUM_REGS)) |=> $stable(regs_flat)); // R9

    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat)); // R7

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strb_n,
    input  logic                       sel_n,
    input  logic                       space_mem,
    input  logic                       host_rd,
    input  logic                       addr_pass,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [DATA_W-1:0]          host_wdata,
    output logic [DATA_W-1:0]          host_rdata,
    output logic                       host_rdata_oe,
    output logic                       buf_en_n,
    output logic                       ready_n,
    output logic                       mem_en,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    input  logic [DATA_W-1:0]          mem_rdata,
    output logic [NUM_REGS*DATA_W-1:0] reg_values
);

    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } top_regs_t;

    top_regs_t         r_d, r_q;
    hbus_state_e       st;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] reg_rdata;
    logic              access_cyc;
    logic              reg_wr;

    hbus_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb_n   (strb_n),
        .sel_n    (sel_n),
        .st_o     (st),
        .buf_en_n (buf_en_n),
        .ready_n  (ready_n)
    );

    hbus_addr_latch #(.ADDR_W(ADDR_W)) i_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .pass     (addr_pass),
        .addr_in  (host_addr),
        .addr_out (eff_addr)
    );

    // The single cycle before ready falls carries the transfer to the target.
    assign access_cyc = (st == ST_ACCESS);
    assign reg_wr     = access_cyc & ~space_mem & ~host_rd;

    hbus_regbank #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (eff_addr),
        .wdata     (host_wdata),
        .rdata     (reg_rdata),
        .regs_flat (reg_values)
    );

    assign mem_en    = access_cyc & space_mem;
    assign mem_we    = mem_en & ~host_rd;
    assign mem_addr  = eff_addr;
    assign mem_wdata = host_wdata;

    always_comb begin
        r_d = r_q;
        if (access_cyc) r_d.rd = reg_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Memory data arrives from the synchronous port in the ready cycle.
    assign host_rdata    = space_mem ? mem_rdata : r_q.rd;
    assign host_rdata_oe = ~buf_en_n & host_rd;

    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R4

    AST_WRITE_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (!buf_en_n && ready_n)); // R5

    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !host_rdata_oe); // R10

    AST_STROBE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        strb_n |-> (!mem_en && !host_rdata_oe)); // R3

    AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> (!mem_en && buf_en_n)); // R13

endmodule

// File: tb/test_hbus_slave.sv
module test_hbus_slave;

    localparam int DW = 16;
    localparam int AW = 16;
    localparam int NR = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strb_n = 1'b1;
    logic          sel_n = 1'b1;
    logic          space_mem = 1'b0;
    logic          host_rd = 1'b0;
    logic          addr_pass = 1'b1;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_rdata_oe;
    logic          buf_en_n;
    logic          ready_n;
    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [NR*DW-1:0] reg_values;

    always #10 clk = ~clk;

    hbus_slave #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR)) i_hbus_slave (
        .clk(clk), .rst_n(rst_n), .strb_n(strb_n), .sel_n(sel_n),
        .space_mem(space_mem), .host_rd(host_rd), .addr_pass(addr_pass),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rdata_oe(host_rdata_oe), .buf_en_n(buf_en_n), .ready_n(ready_n),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .reg_values(reg_values)
    );

    // Environment: the shared memory's host-side port, one cycle read latency.
    logic [DW-1:0] ram [int];
    int we_count = 0;
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[int'(mem_addr)] = mem_wdata;
            else mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : '0;
        end
        if (mem_we) we_count++;
    end

    // Reference model state.
    int            phase = 0;
    logic [AW-1:0] hold = '0;
    logic [DW-1:0] ref_mem [int];
    logic [DW-1:0] ref_reg [NR];
    logic [DW-1:0] exp_rd = '0;
    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] eff_now();
        return addr_pass ? host_addr : hold;
    endfunction

    task automatic model_edge();
        logic [AW-1:0] ea;
        ea = eff_now();
        if (rst_n && addr_pass) hold = host_addr;
        if (strb_n || sel_n || !rst_n) phase = 0;
        else if (phase == 0) phase = 1;
        else if (phase == 1) begin
            phase = 2;
            if (space_mem) begin
                if (!host_rd) ref_mem[int'(ea)] = host_wdata;
                else exp_rd = ref_mem.exists(int'(ea)) ? ref_mem[int'(ea)] : '0;
            end else begin
                if (!host_rd && int'(ea) < NR) ref_reg[int'(ea)] = host_wdata;
                exp_rd = (int'(ea) < NR) ? ref_reg[int'(ea)] : '0;
            end
        end
    endtask

    task automatic compare();
        chk("R1", "buf_en_n", 32'(buf_en_n), 32'(!(phase >= 1)));
        chk("R2", "ready_n", 32'(ready_n), 32'(!(phase == 2)));
        chk("R10", "rdata_oe", 32'(host_rdata_oe), 32'(phase >= 1 && host_rd));
        chk("R5", "mem_en", 32'(mem_en), 32'(phase == 1 && space_mem));
        chk("R5", "mem_we", 32'(mem_we), 32'(phase == 1 && space_mem && !host_rd));
        if (phase == 1 && space_mem) begin
            chk("R5", "mem_addr", 32'(mem_addr), 32'(eff_now()));
            if (!host_rd) chk("R5", "mem_wdata", 32'(mem_wdata), 32'(host_wdata));
        end
        if (phase == 2 && host_rd)
            chk(space_mem ? "R6" : "R8", "read data", 32'(host_rdata), 32'(exp_rd));
        for (int i = 0; i < NR; i++)
            chk("R7", "reg value", 32'(reg_values[i*DW +: DW]), 32'(ref_reg[i]));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic release_strobe();
        strb_n = 1'b1;
        sel_n  = 1'b1;
        phase  = 0;
        #1;
        chk("R3", "buf_en_n async", 32'(buf_en_n), 32'd1);
        chk("R3", "ready_n async", 32'(ready_n), 32'd1);
        chk("R10", "oe after release", 32'(host_rdata_oe), 32'd0);
    endtask

    task automatic access(input logic mem, input logic rd, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input int extra, input int gap);
        space_mem  = mem;
        host_rd    = rd;
        host_addr  = a;
        host_wdata = d;
        strb_n     = 1'b0;
        sel_n      = 1'b0;
        repeat (2 + extra) step();
        release_strobe();
        repeat (gap) step();
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int wc;
        logic [DW-1:0] got;
        for (int i = 0; i < NR; i++) ref_reg[i] = '0;
        repeat (3) step();
        // R12: reset state
        chk("R12", "buf_en_n in reset", 32'(buf_en_n), 32'd1);
        chk("R12", "ready_n in reset", 32'(ready_n), 32'd1);
        chk("R12", "oe in reset", 32'(host_rdata_oe), 32'd0);
        chk("R12", "mem_en in reset", 32'(mem_en), 32'd0);
        chk("R12", "regs in reset", 32'(reg_values == '0), 32'd1);
        rst_n = 1'b1;
        step();

        // R7 / R8: register writes then reads
        for (int i = 0; i < NR; i++) access(1'b0, 1'b0, AW'(i), DW'(16'h1111 * (i + 1) ^ 16'h00A5), 0, 1);
        for (int i = NR - 1; i >= 0; i--) access(1'b0, 1'b1, AW'(i), '0, 0, 1);

        // R5 / R6: memory writes and reads at the edges of the space
        access(1'b1, 1'b0, 16'h0000, 16'hCAFE, 0, 1);
        access(1'b1, 1'b0, 16'hFFFF, 16'h5A5A, 0, 1);
        access(1'b1, 1'b0, 16'h1234, 16'h0F0F, 0, 0);
        access(1'b1, 1'b1, 16'hFFFF, '0, 0, 1);
        access(1'b1, 1'b1, 16'h0000, '0, 0, 1);
        access(1'b1, 1'b1, 16'h1234, '0, 0, 1);
        access(1'b1, 1'b1, 16'h0777, '0, 0, 1);

        // R9: out-of-range register write ignored, reads zero
        access(1'b0, 1'b0, AW'(NR), 16'hDEAD, 0, 1);
        access(1'b0, 1'b0, 16'h00FF, 16'hBEEF, 0, 1);
        host_rd = 1'b1; space_mem = 1'b0; host_addr = AW'(NR);
        strb_n = 1'b0; sel_n = 1'b0;
        step(); step();
        chk("R9", "out-of-range read", 32'(host_rdata), 32'd0);
        release_strobe();
        step();

        // R4: long hold issues one write only
        wc = we_count;
        access(1'b1, 1'b0, 16'h0100, 16'h7777, 5, 1);
        chk("R4", "write count", 32'(we_count - wc), 32'd1);
        access(1'b1, 1'b1, 16'h0100, '0, 4, 1);

        // R13: strobe low with select high starts nothing
        space_mem = 1'b1; host_rd = 1'b0; strb_n = 1'b0; sel_n = 1'b1;
        wc = we_count;
        repeat (3) step();
        chk("R13", "buf_en_n unselected", 32'(buf_en_n), 32'd1);
        chk("R13", "no write unselected", 32'(we_count - wc), 32'd0);
        release_strobe();
        step();

        // R11: held address used while pass is low
        addr_pass = 1'b1; host_addr = 16'h0042;
        step();
        addr_pass = 1'b0; host_addr = 16'h0777;
        step();
        access(1'b1, 1'b0, 16'h0777, 16'hBEEF, 0, 1);
        addr_pass = 1'b1;
        step();
        host_rd = 1'b1; space_mem = 1'b1; host_addr = 16'h0042;
        strb_n = 1'b0; sel_n = 1'b0;
        step(); step();
        got = host_rdata;
        chk("R11", "held address write", 32'(got), 32'h0000BEEF);
        release_strobe();
        step();
        access(1'b1, 1'b1, 16'h0777, '0, 0, 1);

        // R1 / R2 / R3: back-to-back accesses with no idle edge
        access(1'b0, 1'b0, 16'h0003, 16'h3C3C, 0, 0);
        access(1'b0, 1'b1, 16'h0003, '0, 0, 0);
        access(1'b1, 1'b1, 16'hFFFF, '0, 1, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule